// File: doc/BRIEF.md
# Same-Page Bank Arbiter with Load Merging

This block sits between a grouping buffer and a four-bank first-level data cache. Each cycle the buffer presents up to eight requests. All of them lie in one page, and they arrive in priority order, with slot 0 the most urgent. Most are loads. At most one is treated as a write that a merge buffer has evicted. For every bank the arbiter picks one leading request. For a leading load it looks for followers in a short window behind the leader that read the same data, so that they can share a single read. It then caps the number of serviced loads at the number of result buses. It returns an accept mask and a reject mask to the buffer, and it forwards the way-table field of each serviced line to its bank.

Every input shares one page, so only the in-page address bits are presented, and the comparators use only those bits. All outputs are registered and appear one clock after the inputs they depend on.

Top module: `bank_arbiter`

## Requirements
- R1: While rst_ni is low, and after reset until the first clock edge with it high, every output is zero.
- R2: The bank of an entry is in-page address bits [7:6]. For each bank the leading load is the lowest-numbered valid load entry mapped to that bank. bank_lead_o holds its index one clock after the inputs.
- R3: A valid load in one of the three slots directly after a leading load is merged onto that leader when address bits [11:5] match, which covers the same line and the same 32-byte sub-block pair. Loads in the same line but in the other pair are not merged, and nor are loads further than three slots away. An accepted load reports its leader's index on req_lead_o.
- R4: Leaders and merged loads are candidates. Only the first four candidates in slot order are accepted, one for each result bus.
- R5: Only the lowest-numbered valid write entry is considered. It is accepted only if no valid load maps to its bank. It is never merged, and it sets bank_wr_o for its bank.
- R6: reject_o equals valid AND NOT accept. Invalid slots are neither accepted nor rejected.
- R7: For a serviced bank, bank_line_o holds address bits [11:6] of its leading entry, and bank_way_o holds way-table bits [2*line+1 : 2*line]. Both are zero for an idle bank.
- R8: bank_sel_o is set for a bank whose leading load is accepted or whose write is accepted. req_bank_o holds the bank index of each accepted entry and zero for the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 8 | Slot holds a request |
| req_wr_i | input | 8 | Slot holds an evicted write rather than a load |
| req_addr_i | input | 96 | In-page byte address, 12 bits per slot |
| way_tbl_i | input | 128 | Way-table entry of the page, 2 bits per line |
| accept_o | output | 8 | Slot serviced this cycle |
| reject_o | output | 8 | Valid slot held for a later cycle |
| req_bank_o | output | 16 | Bank serving each accepted slot |
| req_lead_o | output | 24 | Leader slot whose read the accepted slot uses |
| bank_sel_o | output | 4 | Bank has an access |
| bank_wr_o | output | 4 | Bank access is the write |
| bank_lead_o | output | 12 | Leading slot of each bank |
| bank_line_o | output | 24 | In-page line index of each bank access |
| bank_way_o | output | 8 | Way field forwarded to each bank |

## Verification
The bench builds the block with its default parameters: eight slots, four banks, four result buses, a merge window of three and 12-bit in-page addresses. A long pseudo-random sweep draws addresses from the first eight lines, with a random sub-block-pair bit. This gives frequent bank collisions, same-line followers inside and outside the window, and groups whose candidate count exceeds the bus limit. Write entries are injected sometimes alone and sometimes in pairs, with their bank sometimes free and sometimes occupied. Directed vectors pin down the window edge, the pair-bit split and reset.

// File: rtl/bank_arb_pkg.sv
package bank_arb_pkg;
  localparam int unsigned N_REQ_D    = 8;
  localparam int unsigned N_BANK_D   = 4;
  localparam int unsigned N_BUS_D    = 4;
  localparam int unsigned WIN_D      = 3;
  localparam int unsigned ADDR_W_D   = 12;
  localparam int unsigned LINE_LSB_D = 6;
  localparam int unsigned PAIR_LSB_D = 5;
  localparam int unsigned WAY_W_D    = 2;
endpackage

// File: rtl/bank_pick.sv
module bank_pick #(
  parameter int unsigned N_REQ  = 8,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned IDX_W  = 3
) (
  input  logic [N_REQ-1:0]        load_v_i,
  input  logic [N_REQ-1:0]        wr_v_i,
  input  logic [N_REQ*BANK_W-1:0] bank_i,
  input  logic [BANK_W-1:0]       my_bank_i,
  output logic                    ld_found_o,
  output logic [IDX_W-1:0]        ld_idx_o,
  output logic                    wr_found_o,
  output logic [IDX_W-1:0]        wr_idx_o
);
  always_comb begin
    ld_found_o = 1'b0;
    ld_idx_o   = '0;
    wr_found_o = 1'b0;
    wr_idx_o   = '0;
    for (int i = N_REQ-1; i >= 0; i--) begin
      if (load_v_i[i] && bank_i[i*BANK_W +: BANK_W] == my_bank_i) begin
        ld_found_o = 1'b1;
        ld_idx_o   = IDX_W'(i);
      end
      if (wr_v_i[i] && bank_i[i*BANK_W +: BANK_W] == my_bank_i) begin
        wr_found_o = 1'b1;
        wr_idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/merge_win.sv
module merge_win #(
  parameter int unsigned N_REQ = 8,
  parameter int unsigned WIN   = 3,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned KEY_W = 7
) (
  input  logic                   found_i,
  input  logic [IDX_W-1:0]       lead_i,
  input  logic [N_REQ-1:0]       load_v_i,
  input  logic [N_REQ*KEY_W-1:0] key_i,
  output logic [N_REQ-1:0]       member_o
);
  logic [KEY_W-1:0] lead_key;

  always_comb begin
    lead_key = '0;
    for (int i = 0; i < N_REQ; i++)
      if (int'(lead_i) == i) lead_key = key_i[i*KEY_W +: KEY_W];
  end

  always_comb begin
    member_o = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (found_i) begin
        if (int'(lead_i) == i)
          member_o[i] = 1'b1;
        else if (load_v_i[i] && i > int'(lead_i) && i <= int'(lead_i) + int'(WIN)
                 && key_i[i*KEY_W +: KEY_W] == lead_key)
          member_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bus_limit.sv
module bus_limit #(
  parameter int unsigned N_REQ = 8,
  parameter int unsigned N_BUS = 4
) (
  input  logic [N_REQ-1:0] cand_i,
  output logic [N_REQ-1:0] keep_o
);
  always_comb begin
    int cnt;
    cnt    = 0;
    keep_o = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (cand_i[i] && cnt < int'(N_BUS)) begin
        keep_o[i] = 1'b1;
        cnt++;
      end
    end
  end
endmodule

// File: rtl/bank_arbiter.sv
module bank_arbiter
  import bank_arb_pkg::*;
#(
  parameter int unsigned N_REQ    = N_REQ_D,
  parameter int unsigned N_BANK   = N_BANK_D,
  parameter int unsigned N_BUS    = N_BUS_D,
  parameter int unsigned WIN      = WIN_D,
  parameter int unsigned ADDR_W   = ADDR_W_D,
  parameter int unsigned LINE_LSB = LINE_LSB_D,
  parameter int unsigned PAIR_LSB = PAIR_LSB_D,
  parameter int unsigned WAY_W    = WAY_W_D,
  localparam int unsigned IDX_W   = $clog2(N_REQ),
  localparam int unsigned BANK_W  = $clog2(N_BANK),
  localparam int unsigned LINE_W  = ADDR_W - LINE_LSB,
  localparam int unsigned KEY_W   = ADDR_W - PAIR_LSB,
  localparam int unsigned N_LINE  = 1 << LINE_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_REQ-1:0]          req_valid_i,
  input  logic [N_REQ-1:0]          req_wr_i,
  input  logic [N_REQ*ADDR_W-1:0]   req_addr_i,
  input  logic [N_LINE*WAY_W-1:0]   way_tbl_i,
  output logic [N_REQ-1:0]          accept_o,
  output logic [N_REQ-1:0]          reject_o,
  output logic [N_REQ*BANK_W-1:0]   req_bank_o,
  output logic [N_REQ*IDX_W-1:0]    req_lead_o,
  output logic [N_BANK-1:0]         bank_sel_o,
  output logic [N_BANK-1:0]         bank_wr_o,
  output logic [N_BANK*IDX_W-1:0]   bank_lead_o,
  output logic [N_BANK*LINE_W-1:0]  bank_line_o,
  output logic [N_BANK*WAY_W-1:0]   bank_way_o
);
  logic [N_REQ-1:0]        load_v, wr_first;
  logic [N_REQ*BANK_W-1:0] bank_of;
  logic [N_REQ*KEY_W-1:0]  key_of;
  logic [N_REQ*LINE_W-1:0] line_of;

  always_comb begin
    logic seen;
    seen     = 1'b0;
    load_v   = req_valid_i & ~req_wr_i;
    wr_first = '0;
    for (int i = 0; i < N_REQ; i++) begin
      bank_of[i*BANK_W +: BANK_W] = req_addr_i[i*ADDR_W + LINE_LSB +: BANK_W];
      key_of[i*KEY_W +: KEY_W]    = req_addr_i[i*ADDR_W + PAIR_LSB +: KEY_W];
      line_of[i*LINE_W +: LINE_W] = req_addr_i[i*ADDR_W + LINE_LSB +: LINE_W];
      if (req_valid_i[i] && req_wr_i[i] && !seen) begin
        wr_first[i] = 1'b1;
        seen        = 1'b1;
      end
    end
  end

  logic [N_BANK-1:0]       ld_found, wr_found;
  logic [IDX_W-1:0]        ld_idx [N_BANK];
  logic [IDX_W-1:0]        wr_idx [N_BANK];
  logic [N_REQ-1:0]        member [N_BANK];

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    bank_pick #(.N_REQ(N_REQ), .BANK_W(BANK_W), .IDX_W(IDX_W)) u_pick (
      .load_v_i  (load_v),
      .wr_v_i    (wr_first),
      .bank_i    (bank_of),
      .my_bank_i (BANK_W'(b)),
      .ld_found_o(ld_found[b]),
      .ld_idx_o  (ld_idx[b]),
      .wr_found_o(wr_found[b]),
      .wr_idx_o  (wr_idx[b])
    );
    merge_win #(.N_REQ(N_REQ), .WIN(WIN), .IDX_W(IDX_W), .KEY_W(KEY_W)) u_merge (
      .found_i (ld_found[b]),
      .lead_i  (ld_idx[b]),
      .load_v_i(load_v),
      .key_i   (key_of),
      .member_o(member[b])
    );
  end

  logic [N_REQ-1:0] cand, keep;
  always_comb begin
    cand = '0;
    for (int b = 0; b < N_BANK; b++) cand = cand | member[b];
  end

  bus_limit #(.N_REQ(N_REQ), .N_BUS(N_BUS)) u_bus (
    .cand_i(cand),
    .keep_o(keep)
  );

  logic [N_REQ-1:0]          acc_d;
  logic [N_REQ*BANK_W-1:0]   rbank_d;
  logic [N_REQ*IDX_W-1:0]    rlead_d;
  logic [N_BANK-1:0]         sel_d, wr_d;
  logic [N_BANK*IDX_W-1:0]   blead_d;
  logic [N_BANK*LINE_W-1:0]  bline_d;
  logic [N_BANK*WAY_W-1:0]   bway_d;

  always_comb begin
    acc_d   = '0;
    rbank_d = '0;
    rlead_d = '0;
    sel_d   = '0;
    wr_d    = '0;
    blead_d = '0;
    bline_d = '0;
    bway_d  = '0;
    for (int b = 0; b < N_BANK; b++) begin
      logic [IDX_W-1:0]  idx;
      logic [LINE_W-1:0] ln;
      idx = '0;
      if (ld_found[b]) begin
        for (int i = 0; i < N_REQ; i++) begin
          if (member[b][i] && keep[i]) begin
            acc_d[i]                      = 1'b1;
            rbank_d[i*BANK_W +: BANK_W]   = BANK_W'(b);
            rlead_d[i*IDX_W +: IDX_W]     = ld_idx[b];
          end
          if (int'(ld_idx[b]) == i && keep[i]) sel_d[b] = 1'b1;
        end
        idx = ld_idx[b];
      end else if (wr_found[b]) begin
        // write only claims a bank no load wants
        sel_d[b] = 1'b1;
        wr_d[b]  = 1'b1;
        idx      = wr_idx[b];
        for (int i = 0; i < N_REQ; i++) begin
          if (int'(wr_idx[b]) == i) begin
            acc_d[i]                    = 1'b1;
            rbank_d[i*BANK_W +: BANK_W] = BANK_W'(b);
            rlead_d[i*IDX_W +: IDX_W]   = IDX_W'(i);
          end
        end
      end
      ln = '0;
      for (int i = 0; i < N_REQ; i++)
        if (int'(idx) == i) ln = line_of[i*LINE_W +: LINE_W];
      if (sel_d[b]) begin
        blead_d[b*IDX_W +: IDX_W]   = idx;
        bline_d[b*LINE_W +: LINE_W] = ln;
        for (int l = 0; l < int'(N_LINE); l++)
          if (int'(ln) == l) bway_d[b*WAY_W +: WAY_W] = way_tbl_i[l*WAY_W +: WAY_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o    <= '0;
      reject_o    <= '0;
      req_bank_o  <= '0;
      req_lead_o  <= '0;
      bank_sel_o  <= '0;
      bank_wr_o   <= '0;
      bank_lead_o <= '0;
      bank_line_o <= '0;
      bank_way_o  <= '0;
    end else begin
      accept_o    <= acc_d;
      reject_o    <= req_valid_i & ~acc_d;
      req_bank_o  <= rbank_d;
      req_lead_o  <= rlead_d;
      bank_sel_o  <= sel_d;
      bank_wr_o   <= wr_d;
      bank_lead_o <= blead_d;
      bank_line_o <= bline_d;
      bank_way_o  <= bway_d;
    end
  end
endmodule

// File: rtl/bank_arb_chk.sv
module bank_arb_chk #(
  parameter int unsigned N_REQ  = 8,
  parameter int unsigned N_BANK = 4,
  parameter int unsigned N_BUS  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_REQ-1:0]  req_valid_i,
  input logic [N_REQ-1:0]  req_wr_i,
  input logic [N_REQ-1:0]  accept_o,
  input logic [N_REQ-1:0]  reject_o,
  input logic [N_BANK-1:0] bank_sel_o,
  input logic [N_BANK-1:0] bank_wr_o
);
  logic [N_REQ-1:0] valid_q, wr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      wr_q    <= '0;
    end else begin
      valid_q <= req_valid_i;
      wr_q    <= req_wr_i;
    end
  end

  AST_ACC_REJ_COVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 ((accept_o | reject_o) == valid_q && (accept_o & reject_o) == '0)); // R6
  AST_BUS_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(accept_o & ~wr_q) <= N_BUS); // R4
  AST_ONE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(accept_o & wr_q) <= 1); // R5
  AST_WR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_wr_o) && (bank_wr_o & ~bank_sel_o) == '0); // R8
  AST_WR_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 ((|(accept_o & wr_q)) == (|bank_wr_o))); // R5
endmodule

bind bank_arbiter bank_arb_chk #(.N_REQ(N_REQ), .N_BANK(N_BANK), .N_BUS(N_BUS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_wr_i   (req_wr_i),
  .accept_o   (accept_o),
  .reject_o   (reject_o),
  .bank_sel_o (bank_sel_o),
  .bank_wr_o  (bank_wr_o)
);

// File: tb/sim_bank_arbiter.sv
module sim_bank_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 3000;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [7:0]   req_valid_i = '0, req_wr_i = '0;
  logic [95:0]  req_addr_i = '0;
  logic [127:0] way_tbl_i = '0;
  logic [7:0]   accept_o, reject_o;
  logic [15:0]  req_bank_o;
  logic [23:0]  req_lead_o;
  logic [3:0]   bank_sel_o, bank_wr_o;
  logic [11:0]  bank_lead_o;
  logic [23:0]  bank_line_o;
  logic [7:0]   bank_way_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bank_arbiter u0 (.*);

  int total = 0, bad = 0;
  bit done = 0;
  logic [11:0] a [8];
  logic [7:0]  e_acc, e_rej;
  logic [15:0] e_rbank;
  logic [23:0] e_rlead;
  logic [3:0]  e_sel, e_wr;
  logic [11:0] e_blead;
  logic [23:0] e_bline;
  logic [7:0]  e_bway;
  logic [31:0] lcg = 32'h1234_5678;

  function automatic logic [31:0] nxt(logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model();
    int lead [4];
    int ldr [8];
    bit cand [8];
    int n, mi, b, ln;
    e_acc = '0; e_rbank = '0; e_rlead = '0; e_sel = '0; e_wr = '0;
    e_blead = '0; e_bline = '0; e_bway = '0;
    for (int i = 0; i < 8; i++) begin cand[i] = 0; ldr[i] = 0; end
    for (int k = 0; k < 4; k++) begin
      lead[k] = -1;
      for (int i = 0; i < 8; i++)
        if (req_valid_i[i] && !req_wr_i[i] && (int'(a[i]) / 64) % 4 == k && lead[k] < 0)
          lead[k] = i;
      if (lead[k] >= 0) begin
        cand[lead[k]] = 1; ldr[lead[k]] = lead[k];
        for (int j = lead[k] + 1; j <= lead[k] + 3 && j < 8; j++)
          if (req_valid_i[j] && !req_wr_i[j] && int'(a[j]) / 32 == int'(a[lead[k]]) / 32) begin
            cand[j] = 1; ldr[j] = lead[k];
          end
      end
    end
    n = 0;
    for (int i = 0; i < 8; i++)
      if (cand[i] && n < 4) begin
        n++;
        e_acc[i] = 1'b1;
        e_rbank[i*2 +: 2] = 2'((int'(a[i]) / 64) % 4);
        e_rlead[i*3 +: 3] = 3'(ldr[i]);
      end
    mi = -1;
    for (int i = 7; i >= 0; i--) if (req_valid_i[i] && req_wr_i[i]) mi = i;
    if (mi >= 0) begin
      b = (int'(a[mi]) / 64) % 4;
      if (lead[b] < 0) begin
        ln = int'(a[mi]) / 64;
        e_acc[mi] = 1'b1; e_rbank[mi*2 +: 2] = 2'(b); e_rlead[mi*3 +: 3] = 3'(mi);
        e_sel[b] = 1'b1; e_wr[b] = 1'b1; e_blead[b*3 +: 3] = 3'(mi);
        e_bline[b*6 +: 6] = 6'(ln); e_bway[b*2 +: 2] = way_tbl_i[2*ln +: 2];
      end
    end
    for (int k = 0; k < 4; k++)
      if (lead[k] >= 0 && e_acc[lead[k]]) begin
        ln = int'(a[lead[k]]) / 64;
        e_sel[k] = 1'b1; e_blead[k*3 +: 3] = 3'(lead[k]);
        e_bline[k*6 +: 6] = 6'(ln); e_bway[k*2 +: 2] = way_tbl_i[2*ln +: 2];
      end
    e_rej = req_valid_i & ~e_acc;
  endtask

  task automatic apply_and_check();
    for (int i = 0; i < 8; i++) req_addr_i[i*12 +: 12] = a[i];
    model();
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R4 accept", 32'(accept_o), 32'(e_acc));
    chk("R6 reject", 32'(reject_o), 32'(e_rej));
    chk("R8 req_bank", 32'(req_bank_o), 32'(e_rbank));
    chk("R3 req_lead", 32'(req_lead_o), 32'(e_rlead));
    chk("R8 bank_sel", 32'(bank_sel_o), 32'(e_sel));
    chk("R5 bank_wr", 32'(bank_wr_o), 32'(e_wr));
    chk("R2 bank_lead", 32'(bank_lead_o), 32'(e_blead));
    chk("R7 bank_line", 32'(bank_line_o), 32'(e_bline));
    chk("R7 bank_way", 32'(bank_way_o), 32'(e_bway));
  endtask

  initial begin
    for (int i = 0; i < 8; i++) a[i] = '0;
    req_valid_i = 8'hFF;
    way_tbl_i = {4{32'hA5C3_9E17}};
    #(CLK_PERIOD*3);
    chk("R1 reset accept", 32'(accept_o), 0);
    chk("R1 reset bank", {bank_sel_o, bank_wr_o, bank_way_o}, 0);
    chk("R1 reset lead", {8'h0, req_lead_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    chk("R1 before edge", {reject_o, req_bank_o, bank_lead_o}, 0);

    // R3 R4: eight loads to one line: window of three, bus limit four
    req_wr_i = '0;
    for (int i = 0; i < 8; i++) a[i] = 12'h0C4 + 12'(i);
    apply_and_check();
    chk("R3 window edge", 32'(accept_o), 32'h0F);
    // R3: same line, other sub-block pair -> not merged
    a[1] = 12'h0E0; a[2] = 12'h0E8;
    apply_and_check();
    chk("R3 pair split", 32'(accept_o), 32'h09);
    // R5: write to a bank free of loads, second write ignored
    req_valid_i = 8'h0F; req_wr_i = 8'h0C;
    a[0] = 12'h000; a[1] = 12'h040; a[2] = 12'h0C0; a[3] = 12'h080;
    apply_and_check();
    chk("R5 first write only", 32'(accept_o), 32'h07);
    // R5: write whose bank has a load is rejected
    a[2] = 12'h040;
    apply_and_check();
    chk("R5 write blocked", 32'(bank_wr_o), 0);

    for (int v = 0; v < NVEC; v++) begin
      lcg = nxt(lcg); req_valid_i = lcg[15:8];
      lcg = nxt(lcg);
      req_wr_i = '0;
      if (lcg[20]) req_wr_i[lcg[18:16]] = 1'b1;
      if (lcg[21] && lcg[22]) req_wr_i[lcg[26:24]] = 1'b1;
      if (v % 4 == 0) begin
        lcg = nxt(lcg); way_tbl_i[31:0] = lcg;
        lcg = nxt(lcg); way_tbl_i[63:32] = lcg;
      end
      for (int i = 0; i < 8; i++) begin
        lcg = nxt(lcg);
        a[i] = {lcg[30] ? 3'd0 : 3'(lcg[29:27]), lcg[24:22], lcg[21:16]};
        if (v % 2 == 0) a[i][11:9] = 3'd0;
      end
      apply_and_check();
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule